// File: doc/BRIEF.md
# Filtered Cache Event Counter

This block is one performance counter attached to a shared last-level cache slice. Each cycle the slice may present one event pulse. The pulse carries an event code, the index of the core or thread that caused it, a 3-bit request class and a 5-bit code for where the data came from. The counter adds one only when all of the following hold:

- the pulse is valid;
- counting is enabled;
- the event code matches the selected event;
- the pulse passes three filters: a per-core bitmap, a request-class selector and a data-source match.

When every filter is off, the counter totals every occurrence of the selected event.

Software sets the counter up through a write-only register port with a 3-bit address. The port also lets software preset the 48-bit count and acknowledge the sticky overflow interrupt. The running count and the interrupt are visible on output ports at all times.

Top module: `evtcnt_top`

## Requirements
- R1: After reset the count is zero, the interrupt is low, counting is disabled, the event select is 0 and all three filters are off.
- R2: Address 0 holds the counting enable in bit 0 and the event select in bits [8 +: EVT_W]. The count goes up by exactly one after each cycle in which a valid event passes all filters while counting is enabled and its code equals the select. In every other cycle the count holds, unless a preset happens.
- R3: Address 1 holds a core bitmap in its low NCORES bits. When the bitmap is nonzero, an event from core i is admitted only if bit i is set. An all-zero bitmap admits every core.
- R4: Address 2 holds a 3-bit request filter:
  - 3'b100 admits only reads (class 3'b100);
  - 3'b101 admits only writes (3'b101);
  - 3'b110 admits only atomic stores (3'b110);
  - 3'b111 admits only atomic non-stores (3'b111);
  - 3'b000 and the reserved codes 3'b001 to 3'b011 admit every class.
- R5: Address 3 holds a data-source enable in bit 8 and a 5-bit source code in bits [4:0]. With the enable set, only events whose source code equals the stored code pass. With it clear, any source passes. The named source codes are:
  - 5'b00001: local-die cache;
  - 5'b01000: cross-die cache;
  - 5'b01001: other-socket cache;
  - 5'b01110: local DDR;
  - 5'b01111: cross-die DDR;
  - 5'b10000: cross-socket DDR.
- R6: An increment from the all-ones count wraps the count to zero and sets the overflow interrupt. The interrupt stays set until it is cleared.
- R7: A write to address 5 with bit 0 set clears the interrupt. A write there with bit 0 clear leaves it alone. If a wrap happens in the same cycle as a clear, the interrupt ends up set.
- R8: A write to address 4 loads the written 48-bit value into the count. If a qualifying event arrives in the same cycle, the loaded value wins and the event is not added.
- R9: A configuration write affects only events in later cycles. An event arriving in the same cycle as the write is judged by the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | CNT_W | Register write data |
| evtValid | input | 1 | Event pulse present this cycle |
| evtCode | input | EVT_W | Event code of the pulse |
| evtCore | input | $clog2(NCORES) | Originating core/thread index |
| evtReq | input | 3 | Request class of the pulse |
| evtSrc | input | 5 | Data-source code of the pulse |
| countVal | output | CNT_W | Current count |
| ovfIrq | output | 1 | Sticky overflow interrupt |

## Verification
Two pairs of functions can land in the same cycle. The first is a counter wrap and a write-one clear of the interrupt. The bench presets the count to all ones, then in one cycle drives both a qualifying event and a clear write. It expects a zero count and a set interrupt. The second pair is a preset write and a qualifying event; there the expected count is the written value, with no increment. A configuration write in the same cycle as an event is judged against the settings that were in force before the write.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

  typedef struct packed {
    logic inc;
    logic load;
    logic clrOvf;
  } cntStrobe_t;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_CORE   = 3'd1;
  localparam logic [2:0] ADDR_REQ    = 3'd2;
  localparam logic [2:0] ADDR_SRC    = 3'd3;
  localparam logic [2:0] ADDR_PRESET = 3'd4;
  localparam logic [2:0] ADDR_OVF    = 3'd5;

  localparam int SEL_LSB    = 8;
  localparam int SRC_EN_BIT = 8;
  localparam int REQ_W      = 3;
  localparam int SRC_W      = 5;

endpackage

// File: rtl/evtcnt_ctrl.sv
module evtcnt_ctrl
  import evtcnt_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int EVT_W  = 4,
  parameter int DATA_W = 48,
  localparam int CORE_W = $clog2(NCORES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              evtValid,
  input  logic [EVT_W-1:0]  evtCode,
  input  logic [CORE_W-1:0] evtCore,
  input  logic [REQ_W-1:0]  evtReq,
  input  logic [SRC_W-1:0]  evtSrc,
  output cntStrobe_t        strobe
);

  logic              cntEnable;
  logic [EVT_W-1:0]  evtSel;
  logic [NCORES-1:0] coreMask;
  logic [REQ_W-1:0]  reqFilt;
  logic              srcEn;
  logic [SRC_W-1:0]  srcCode;

  logic wrCtrl, wrCore, wrReq, wrSrc;
  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
  assign wrCore = regWrEn && (regAddr == ADDR_CORE);
  assign wrReq  = regWrEn && (regAddr == ADDR_REQ);
  assign wrSrc  = regWrEn && (regAddr == ADDR_SRC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntEnable <= 1'b0;
      evtSel    <= '0;
      coreMask  <= '0;
      reqFilt   <= '0;
      srcEn     <= 1'b0;
      srcCode   <= '0;
    end else begin
      if (wrCtrl) begin
        cntEnable <= regWrData[0];
        evtSel    <= regWrData[SEL_LSB +: EVT_W];
      end
      if (wrCore) coreMask <= regWrData[NCORES-1:0];
      if (wrReq)  reqFilt  <= regWrData[REQ_W-1:0];
      if (wrSrc) begin
        srcEn   <= regWrData[SRC_EN_BIT];
        srcCode <= regWrData[SRC_W-1:0];
      end
    end
  end

  logic unusedWrBits;
  assign unusedWrBits = ^regWrData;

  // Core bitmap filter: one match term per core slot.
  logic [NCORES-1:0] coreHit;
  for (genvar gi = 0; gi < NCORES; gi++) begin : g_core
    assign coreHit[gi] = coreMask[gi] && (evtCore == CORE_W'(gi));
  end

  logic corePass, reqPass, srcPass, selHit;
  // Every defined request code has bit 2 set; 000..011 means no filtering.
  assign corePass = (coreMask == '0) || (|coreHit);
  assign reqPass  = !reqFilt[2] || (evtReq == reqFilt);
  assign srcPass  = !srcEn || (evtSrc == srcCode);
  assign selHit   = evtValid && cntEnable && (evtCode == evtSel);

  always_comb begin
    strobe.inc    = selHit && corePass && reqPass && srcPass;
    strobe.load   = regWrEn && (regAddr == ADDR_PRESET);
    strobe.clrOvf = regWrEn && (regAddr == ADDR_OVF) && regWrData[0];
  end

  AST_SEL_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inc |-> (evtValid && cntEnable && evtCode == evtSel)); // R2
  AST_CORE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && coreMask != '0) |-> coreMask[evtCore]); // R3
  AST_REQ_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && reqFilt[2]) |-> (evtReq == reqFilt)); // R4
  AST_SRC_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && srcEn) |-> (evtSrc == srcCode)); // R5
  AST_CFG_REGISTERED: assert property (@(posedge clk) disable iff (!rstN)
    !wrCore |=> $stable(coreMask)); // R9

endmodule

// File: rtl/evtcnt_datapath.sv
module evtcnt_datapath
  import evtcnt_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic wrapNow;
  assign wrapNow = strobe.inc && !strobe.load && (count == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.load) begin
      count <= loadVal;
    end else if (strobe.inc) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovf <= 1'b0;
    end else if (wrapNow) begin
      ovf <= 1'b1;
    end else if (strobe.clrOvf) begin
      ovf <= 1'b0;
    end
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.inc && !strobe.load) |=> $stable(count)); // R2
  AST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && !strobe.load && count != CNT_MAX) |=> (count == $past(count) + 1'b1)); // R2
  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (count == $past(loadVal))); // R8
  AST_WRAP_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && !strobe.load && count == CNT_MAX) |=> (ovf && count == '0)); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !strobe.clrOvf) |=> ovf); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrOvf && !(strobe.inc && !strobe.load && count == CNT_MAX)) |=> !ovf); // R7

endmodule

// File: rtl/evtcnt_top.sv
module evtcnt_top
  import evtcnt_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int EVT_W  = 4,
  parameter int CNT_W  = 48
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic [2:0]                regAddr,
  input  logic [CNT_W-1:0]          regWrData,
  input  logic                      evtValid,
  input  logic [EVT_W-1:0]          evtCode,
  input  logic [$clog2(NCORES)-1:0] evtCore,
  input  logic [2:0]                evtReq,
  input  logic [4:0]                evtSrc,
  output logic [CNT_W-1:0]          countVal,
  output logic                      ovfIrq
);

  cntStrobe_t strobe;

  evtcnt_ctrl #(
    .NCORES(NCORES),
    .EVT_W (EVT_W),
    .DATA_W(CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .evtValid (evtValid),
    .evtCode  (evtCode),
    .evtCore  (evtCore),
    .evtReq   (evtReq),
    .evtSrc   (evtSrc),
    .strobe   (strobe)
  );

  evtcnt_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .loadVal(regWrData),
    .count  (countVal),
    .ovf    (ovfIrq)
  );

endmodule

// File: tb/evtcnt_top_test.sv
module evtcnt_top_test;

  localparam int NC = 4;
  localparam logic [47:0] MAXV = {48{1'b1}};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [47:0] regWrData = '0;
  logic        evtValid = 1'b0;
  logic [3:0]  evtCode = '0;
  logic [1:0]  evtCore = '0;
  logic [2:0]  evtReq = '0;
  logic [4:0]  evtSrc = '0;
  logic [47:0] countVal;
  logic        ovfIrq;

  int errors = 0;
  int checks = 0;

  // Bench mirror of the configuration.
  bit          mEn = 0;
  logic [3:0]  mSel = '0;
  logic [3:0]  mMask = '0;
  logic [2:0]  mReq = '0;
  bit          mSrcEn = 0;
  logic [4:0]  mSrc = '0;
  logic [47:0] expCnt = '0;
  bit          expIrq = 0;

  always #5 clk = ~clk;

  evtcnt_top #(.NCORES(NC), .EVT_W(4), .CNT_W(48)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .evtValid(evtValid), .evtCode(evtCode),
    .evtCore(evtCore), .evtReq(evtReq), .evtSrc(evtSrc),
    .countVal(countVal), .ovfIrq(ovfIrq)
  );

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic bit modelPass(input logic [3:0] code, input logic [1:0] core,
                                   input logic [2:0] req, input logic [4:0] src);
    bit okCore, okReq, okSrc;
    okCore = (mMask == 4'd0) ? 1'b1 : mMask[core];
    okReq  = (mReq inside {3'b100, 3'b101, 3'b110, 3'b111}) ? (req == mReq) : 1'b1;
    okSrc  = mSrcEn ? (src == mSrc) : 1'b1;
    return mEn && (code == mSel) && okCore && okReq && okSrc;
  endfunction

  // One clock cycle: optional write and optional event, starting at a negedge.
  task automatic cyc(input string tag, input bit doWr, input logic [2:0] a,
                     input logic [47:0] d, input bit ev, input logic [3:0] code,
                     input logic [1:0] core, input logic [2:0] req, input logic [4:0] src);
    bit pass, isLoad, wrap;
    regWrEn = doWr; regAddr = a; regWrData = d;
    evtValid = ev; evtCode = code; evtCore = core; evtReq = req; evtSrc = src;
    pass   = ev && modelPass(code, core, req, src);
    isLoad = doWr && (a == 3'd4);
    wrap   = pass && !isLoad && (expCnt == MAXV);
    if (isLoad) expCnt = d;
    else if (pass) expCnt = expCnt + 48'd1;
    if (wrap) expIrq = 1;
    else if (doWr && a == 3'd5 && d[0]) expIrq = 0;
    if (doWr) begin
      case (a)
        3'd0: begin mEn = d[0]; mSel = d[11:8]; end
        3'd1: mMask = d[3:0];
        3'd2: mReq = d[2:0];
        3'd3: begin mSrcEn = d[8]; mSrc = d[4:0]; end
        default: ;
      endcase
    end
    @(negedge clk);
    regWrEn = 1'b0; evtValid = 1'b0;
    check(tag, countVal, expCnt);
    check(tag, {47'd0, ovfIrq}, {47'd0, expIrq});
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [47:0] d);
    cyc(tag, 1, a, d, 0, 0, 0, 0, 0);
  endtask

  task automatic ev(input string tag, input logic [3:0] code, input logic [1:0] core,
                    input logic [2:0] req, input logic [4:0] src);
    cyc(tag, 0, 0, 0, 1, code, core, req, src);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [4:0] srcList [6];
    srcList = '{5'b00001, 5'b01000, 5'b01001, 5'b01110, 5'b01111, 5'b10000};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", countVal, 48'd0);
    check("R1", {47'd0, ovfIrq}, 48'd0);
    // R1: counting disabled after reset, select 0
    ev("R1", 4'd0, 2'd1, 3'd4, 5'd1);
    // R1: filters off by default once enabled with select 0
    wr("R1", 3'd0, 48'h001);
    for (int c = 0; c < NC; c++) ev("R1", 4'd0, 2'(c), 3'(c + 3), 5'(c * 7));

    // R2: event select sweep
    wr("R2", 3'd0, 48'h301);
    for (int code = 0; code < 16; code++)
      for (int c = 0; c < NC; c++) ev("R2", 4'(code), 2'(c), 3'd0, 5'd0);
    wr("R2", 3'd0, 48'h300);
    ev("R2", 4'd3, 2'd0, 3'd0, 5'd0);
    wr("R2", 3'd0, 48'h301);

    // R3: core bitmap sweep
    for (int m = 0; m < 16; m++) begin
      wr("R3", 3'd1, 48'(m));
      for (int c = 0; c < NC; c++) ev("R3", 4'd3, 2'(c), 3'd5, 5'd2);
    end
    wr("R3", 3'd1, 48'd0);

    // R4: request filter sweep
    for (int f = 0; f < 8; f++) begin
      wr("R4", 3'd2, 48'(f));
      for (int r = 0; r < 8; r++) ev("R4", 4'd3, 2'd1, 3'(r), 5'd3);
    end
    wr("R4", 3'd2, 48'd0);

    // R5: data-source filter
    for (int k = 0; k < 6; k++) begin
      wr("R5", 3'd3, 48'h100 | 48'(srcList[k]));
      for (int s = 0; s < 32; s++) ev("R5", 4'd3, 2'd2, 3'd6, 5'(s));
    end
    wr("R5", 3'd3, 48'h00E);
    for (int s = 0; s < 32; s += 5) ev("R5", 4'd3, 2'd2, 3'd6, 5'(s));

    // R8: preset load
    wr("R8", 3'd4, 48'h1234_5678_9ABC);
    // R6: wrap from all ones
    wr("R6", 3'd4, MAXV - 48'd1);
    ev("R6", 4'd3, 2'd0, 3'd0, 5'd0);
    ev("R6", 4'd3, 2'd0, 3'd0, 5'd0);
    ev("R6", 4'd5, 2'd0, 3'd0, 5'd0);
    // R7: write of 0 leaves flag, write of 1 clears
    wr("R7", 3'd5, 48'd0);
    wr("R7", 3'd5, 48'd1);
    // R7: wrap and clear in the same cycle, set wins
    wr("R7", 3'd4, MAXV);
    cyc("R7", 1, 3'd5, 48'd1, 1, 4'd3, 2'd1, 3'd0, 5'd0);
    wr("R7", 3'd5, 48'd1);
    // R8: preset and event in the same cycle, preset wins
    cyc("R8", 1, 3'd4, 48'd100, 1, 4'd3, 2'd1, 3'd0, 5'd0);
    // R8: preset to all ones with event at the same time does not wrap
    cyc("R8", 1, 3'd4, MAXV, 1, 4'd3, 2'd1, 3'd0, 5'd0);
    wr("R8", 3'd4, 48'd7);

    // R9: config write in the same cycle as an event uses old settings
    cyc("R9", 1, 3'd1, 48'h1, 1, 4'd3, 2'd2, 3'd0, 5'd0);
    ev("R9", 4'd3, 2'd2, 3'd0, 5'd0);
    cyc("R9", 1, 3'd0, 48'h500, 1, 4'd3, 2'd0, 3'd0, 5'd0);
    ev("R9", 4'd3, 2'd0, 3'd0, 5'd0);

    finishRun();
  end

endmodule